// File: doc/BRIEF.md
# Zoned Address Remapper

This block sits on the path from a CPU memory port to the memory bus and turns each CPU address into a physical bus address. An address in one of the two directly mapped kernel segments (top two bits `10`) first loses its three segment bits, which gives the logical address. Any other CPU address is already logical and is not changed.

The logical address is then compared against three fixed windows of different sizes. Each window has a 32-bit map register that software writes. The low 31 bits of the matching register are added to the logical address, and the sum is the 31-bit physical address. A logical address that lies in no window leaves the block with its low 31 bits unchanged, and an error flag is raised with it. The valid/ready handshake passes straight through, and the address rewrite is purely combinational.

Typical setups are a linear map, with every register left at zero, and a split map in which the large high window is shifted down so that it sits directly above the low memory.

Top module: `zone_remap`

## Requirements
- R1: After reset, all three map registers read back 0x00000000 and every in-zone address maps to itself.
- R2: A CPU address whose bits [31:30] are `10` has bits [31:29] cleared to form the logical address (0x81230000 gives logical 0x01230000). Any other CPU address is used as the logical address unchanged.
- R3: Logical addresses 0x00000000 to 0x0FFFFFFF belong to window A, whose map register is at register offset 0x00.
- R4: Logical addresses 0x10000000 to 0x13FFFFFF belong to window B, whose map register is at register offset 0x10.
- R5: Logical addresses 0x20000000 to 0x9FFFFFFF belong to window C, whose map register is at register offset 0x20.
- R6: For an in-zone address, the physical output is (logical + map[30:0]) mod 2^31. With window C set to 0x70000000, logical 0x20000000 gives 0x10000000.
- R7: For a logical address in no window (0x14000000 to 0x1FFFFFFF, or 0xA0000000 and above), `mem_addr_o` equals logical[30:0] and `mem_oob_o` is 1. For an in-zone address, `mem_oob_o` is 0.
- R8: `mem_valid_o` always equals `req_valid_i`, and `req_ready_o` always equals `mem_ready_i`, in the same cycle.
- R9: A register write is taken on the rising clock edge while `reg_we_i` is 1. From the next cycle, the new value applies to requests and is returned, all 32 bits, on `reg_rdata_o` for a matching `reg_addr_i`. Reads are combinational.
- R10: A write to any offset other than 0x00, 0x10 or 0x20 changes no map register, and a read from such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| req_valid_i | input | 1 | CPU request valid |
| req_addr_i | input | 32 | CPU address |
| req_ready_o | output | 1 | Ready returned to the CPU |
| mem_valid_o | output | 1 | Request valid to the bus |
| mem_addr_o | output | 31 | Physical address |
| mem_oob_o | output | 1 | Logical address lies in no window |
| mem_ready_i | input | 1 | Bus ready |

## Verification
The assertions assume that `reg_addr_i` and `reg_we_i` are known after reset, and that a request address is stable for the whole cycle in which it is checked. To meet this, the bench changes inputs only on the falling edge. The write-then-use property only looks at cycles in which no second write follows at once. The directed tasks therefore leave an idle cycle after each write before they send addresses through. The window-boundary properties use CPU addresses whose top bits are not `10`, so that the logical address is known at the port without modelling the segment logic.

// File: rtl/zr_pkg.sv
package zr_pkg;
  localparam int unsigned CPU_AW   = 32;
  localparam int unsigned PHYS_AW  = 31;
  localparam int unsigned REG_AW   = 6;
  localparam int unsigned REG_DW   = 32;
  localparam int unsigned N_ZONES  = 3;
  localparam int unsigned ZONE_SH  = 4;   // register stride 16 bytes
  localparam int unsigned SEG_BITS = 3;

  typedef logic [CPU_AW-1:0] cpu_addr_t;
  typedef logic [PHYS_AW-1:0] phys_addr_t;
  typedef logic [REG_DW-1:0] map_word_t;

  function automatic cpu_addr_t zone_lo(input int unsigned idx);
    case (idx)
      0:       return 32'h0000_0000;
      1:       return 32'h1000_0000;
      default: return 32'h2000_0000;
    endcase
  endfunction

  function automatic cpu_addr_t zone_hi(input int unsigned idx);
    case (idx)
      0:       return 32'h0FFF_FFFF;
      1:       return 32'h13FF_FFFF;
      default: return 32'h9FFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/zr_seg_strip.sv
module zr_seg_strip
  import zr_pkg::*;
(
  input  cpu_addr_t cpu_addr_i,
  output cpu_addr_t log_addr_o
);
  logic direct_seg;
  assign direct_seg = (cpu_addr_i[CPU_AW-1 -: 2] == 2'b10);

  always_comb begin
    log_addr_o = cpu_addr_i;
    if (direct_seg) log_addr_o[CPU_AW-1 -: SEG_BITS] = '0;
  end
endmodule

// File: rtl/zr_zone_decode.sv
module zr_zone_decode
  import zr_pkg::*;
#(
  parameter int unsigned NZ = N_ZONES
) (
  input  cpu_addr_t        log_addr_i,
  output logic [NZ-1:0]    hit_o
);
  for (genvar z = 0; z < NZ; z++) begin : g_zone
    localparam cpu_addr_t LO = zone_lo(z);
    localparam cpu_addr_t HI = zone_hi(z);
    assign hit_o[z] = (log_addr_i >= LO) && (log_addr_i <= HI);
  end
endmodule

// File: rtl/zr_map_regs.sv
module zr_map_regs
  import zr_pkg::*;
#(
  parameter int unsigned NZ = N_ZONES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  map_word_t           wdata_i,
  output map_word_t           rdata_o,
  output map_word_t [NZ-1:0]  map_o
);
  logic [NZ-1:0] sel;

  for (genvar z = 0; z < NZ; z++) begin : g_reg
    localparam logic [REG_AW-1:0] OFS = REG_AW'(z << ZONE_SH);
    assign sel[z] = (addr_i == OFS);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           map_o[z] <= '0;
      else if (we_i && sel[z]) map_o[z] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int z = 0; z < NZ; z++) begin
      if (sel[z]) rdata_o = rdata_o | map_o[z];
    end
  end
endmodule

// File: rtl/zone_remap.sv
module zone_remap
  import zr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [REG_DW-1:0]   reg_wdata_i,
  output logic [REG_DW-1:0]   reg_rdata_o,
  input  logic                req_valid_i,
  input  logic [CPU_AW-1:0]   req_addr_i,
  output logic                req_ready_o,
  output logic                mem_valid_o,
  output logic [PHYS_AW-1:0]  mem_addr_o,
  output logic                mem_oob_o,
  input  logic                mem_ready_i
);
  cpu_addr_t                 log_addr;
  logic [N_ZONES-1:0]        hit;
  map_word_t [N_ZONES-1:0]   map;
  phys_addr_t                ofs;

  zr_seg_strip u_strip (
    .cpu_addr_i (req_addr_i),
    .log_addr_o (log_addr)
  );

  zr_zone_decode #(.NZ(N_ZONES)) u_dec (
    .log_addr_i (log_addr),
    .hit_o      (hit)
  );

  zr_map_regs #(.NZ(N_ZONES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .map_o   (map)
  );

  // windows are disjoint, so OR-select is exact
  always_comb begin
    ofs = '0;
    for (int z = 0; z < N_ZONES; z++) begin
      if (hit[z]) ofs = ofs | map[z][PHYS_AW-1:0];
    end
  end

  assign mem_addr_o  = log_addr[PHYS_AW-1:0] + ofs;
  assign mem_oob_o   = ~|hit;
  assign mem_valid_o = req_valid_i;
  assign req_ready_o = mem_ready_i;
endmodule

// File: rtl/zone_remap_chk.sv
module zone_remap_chk
  import zr_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_we_i,
  input logic [REG_AW-1:0]   reg_addr_i,
  input logic [REG_DW-1:0]   reg_wdata_i,
  input logic [REG_DW-1:0]   reg_rdata_o,
  input logic                req_valid_i,
  input logic [CPU_AW-1:0]   req_addr_i,
  input logic                req_ready_o,
  input logic                mem_valid_o,
  input logic [PHYS_AW-1:0]  mem_addr_o,
  input logic                mem_oob_o,
  input logic                mem_ready_i
);
  logic plain;
  assign plain = (req_addr_i[31:30] != 2'b10);

  AST_VALID_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o == req_valid_i); // R8
  AST_READY_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o == mem_ready_i); // R8
  AST_GAP_OOB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_addr_i >= 32'h1400_0000 && req_addr_i < 32'h2000_0000) |-> mem_oob_o); // R7
  AST_OOB_UNCHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_oob_o && plain) |-> (mem_addr_o == req_addr_i[30:0])); // R7
  AST_LOW_IN_ZONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_addr_i < 32'h1000_0000) |-> !mem_oob_o); // R3
  AST_WR_APPLIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 6'h00) ##1 (!reg_we_i && req_addr_i < 32'h1000_0000)
      |-> (mem_addr_o == 31'(req_addr_i[30:0] + $past(reg_wdata_i[30:0])))); // R9
  AST_BAD_OFS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i != 6'h00 && reg_addr_i != 6'h10 && reg_addr_i != 6'h20)
      |-> (reg_rdata_o == '0)); // R10
endmodule

bind zone_remap zone_remap_chk u_chk (.*);

// File: tb/zone_remap_tb_top.sv
`timescale 1ns/1ps
module zone_remap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic        mem_valid;
  logic [30:0] mem_addr;
  logic        mem_oob;
  logic        mem_ready = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  zone_remap dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_oob_o(mem_oob), .mem_ready_i(mem_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 6'h3F;
    @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic xl(input string tag, input logic [31:0] a, input logic [30:0] exp, input logic oob);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    #1;
    chk({tag, " addr"}, {1'b0, mem_addr}, {1'b0, exp});
    chk({tag, " oob"}, {31'b0, mem_oob}, {31'b0, oob});
  endtask

  task automatic t_reset;
    rd("R1 map A", 6'h00, 32'h0);
    rd("R1 map B", 6'h10, 32'h0);
    rd("R1 map C", 6'h20, 32'h0);
    xl("R1 identity", 32'h0123_4567, 31'h0123_4567, 1'b0);
    xl("R2 kseg strip", 32'h8123_0000, 31'h0123_0000, 1'b0);
  endtask

  task automatic t_zone_a;
    wr(6'h00, 32'h0000_1000);
    rd("R9 readback A", 6'h00, 32'h0000_1000);
    xl("R3 low", 32'h0000_0010, 31'h0000_1010, 1'b0);
    xl("R3 top edge", 32'h0FFF_FFFF, 31'h1000_0FFF, 1'b0);
    xl("R2 uncached seg", 32'hA000_0000, 31'h0000_1000, 1'b0);
  endtask

  task automatic t_zone_b;
    wr(6'h10, 32'h0200_0000);
    xl("R4 base", 32'h1000_0000, 31'h1200_0000, 1'b0);
    xl("R4 top edge", 32'h13FF_FFFF, 31'h15FF_FFFF, 1'b0);
    xl("R2 cached seg to B", 32'h9000_0020, 31'h1200_0020, 1'b0);
    xl("R7 gap start", 32'h1400_0000, 31'h1400_0000, 1'b1);
    xl("R7 gap end", 32'h1FFF_FFFF, 31'h1FFF_FFFF, 1'b1);
  endtask

  task automatic t_zone_c;
    wr(6'h20, 32'h7000_0000);
    xl("R5 R6 base wraps", 32'h2000_0000, 31'h1000_0000, 1'b0);
    xl("R6 upper", 32'h7FFF_FFFF, 31'h6FFF_FFFF, 1'b0);
    xl("R7 mapped seg", 32'hC000_0004, 31'h4000_0004, 1'b1);
    wr(6'h20, 32'hF000_0000);
    rd("R9 full word", 6'h20, 32'hF000_0000);
    xl("R6 bit31 dropped", 32'h2000_0000, 31'h1000_0000, 1'b0);
  endtask

  task automatic t_bad_ofs;
    wr(6'h08, 32'hDEAD_BEEF);
    wr(6'h04, 32'h1234_5678);
    rd("R10 read 08", 6'h08, 32'h0);
    rd("R10 read 04", 6'h04, 32'h0);
    rd("R10 A intact", 6'h00, 32'h0000_1000);
    rd("R10 B intact", 6'h10, 32'h0200_0000);
    xl("R10 map unchanged", 32'h0000_0010, 31'h0000_1010, 1'b0);
  endtask

  task automatic t_handshake;
    @(negedge clk);
    req_valid = 1'b1; mem_ready = 1'b0;
    #1;
    chk("R8 valid hi", {31'b0, mem_valid}, 32'd1);
    chk("R8 ready lo", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0; mem_ready = 1'b1;
    #1;
    chk("R8 valid lo", {31'b0, mem_valid}, 32'd0);
    chk("R8 ready hi", {31'b0, req_ready}, 32'd1);
  endtask

  initial begin
    reg_addr = 6'h3F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zone_a();
    t_zone_b();
    t_zone_c();
    t_bad_ofs();
    t_handshake();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule